// File: doc/BRIEF.md
# Data-Line Mux Select Controller

This block drives one logic-level select output that steers a USB data-line multiplexer. When the output is high, the data lines go to the charger's source-type detector. When it is low, they go to the system. The output is high while a source-type detection runs. After detection it stays high only for the high-power adapter classes. It drops low for every other class. A force control can hold the output high whenever an input source is present or OTG mode is active. When the device runs from the battery alone with OTG off, the output is held low.

The detection busy and done indications count only while the detection enable is on. That enable is automatic detection, or a one-off forced detection request. The class code seen at the end of detection is turned into a single "high-power" flag and latched. The latched flag is cleared when the input source goes away. A small state machine with five named states picks the output. It uses a fixed priority: battery-only low, then force, then detection in progress, then the latched result. The output comes from a register, so it follows its inputs one clock edge later.

The states are LOW, DETECT, HOLD, FORCED and BATT. On every clock edge, any state moves to the highest-priority target whose condition holds:
- BATT when battery-only is set and OTG is off.
- Otherwise FORCED when force is set and the input is present or OTG is on.
- Otherwise DETECT when detection is busy and enabled.
- Otherwise HOLD when the latched (or the just-arriving) result is high-power.
- Otherwise LOW.

The output is high in DETECT, HOLD and FORCED.

Top module: `dsel_mux_ctrl`

## Requirements
- R1: After reset the select output is low.
- R2: When detection is busy and detection is enabled (automatic enable or forced detection request), the output is high on the next clock edge.
- R3: Busy and done indications arriving while neither automatic nor forced detection is enabled have no effect: the output stays low and no result is latched.
- R4: On an enabled done with class code 3, 4 or 5 (the high-power classes under the default mask), the output is high, and it stays high after busy and done drop.
- R5: On an enabled done with any class code other than 3, 4 or 5 (codes 0, 1, 2, 6, 7), the output is low once busy drops.
- R6: When the input-present flag drops, the latched result is cleared. The output goes low and stays low after the input returns, until a new detection completes.
- R7: Force set while the input is present or OTG is on drives the output high, whatever class was latched.
- R8: Force set with no input present and OTG off has no effect on the output.
- R9: Battery-only set with OTG off forces the output low over force, busy and a latched high-power result. The latched result is kept and takes effect again when battery-only clears.
- R10: Battery-only set while OTG is on does not override: force still drives the output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_auto_en_i | input | 1 | Automatic source detection enabled |
| det_force_i | input | 1 | Forced source detection requested |
| det_busy_i | input | 1 | Detection in progress |
| det_done_i | input | 1 | Detection finished, class code valid |
| det_type_i | input | TYPE_W (3) | Detected source class code |
| in_present_i | input | 1 | Input source present |
| otg_on_i | input | 1 | OTG (reverse supply) mode active |
| batt_only_i | input | 1 | Running from battery only |
| force_sel_i | input | 1 | Force select high |
| sel_o | output | 1 | Registered data-line mux select |

## Verification
The bench builds the block with the default parameters. These are a 3-bit class code and a high-power mask with codes 3, 4 and 5 set, so all eight class codes can be swept, and each of them is driven through a full detection. With this width every code on either side of the mask boundary gets exercised. Directed scenarios then layer force, OTG and battery-only over a latched result, to reach every priority level of the state machine.

// File: rtl/dsel_pkg.sv
package dsel_pkg;

    localparam int DEF_TYPE_W = 3;
    localparam logic [7:0] DEF_HP_MASK = 8'b0011_1000;

    typedef enum logic [2:0] {
        ST_LOW    = 3'd0,
        ST_DETECT = 3'd1,
        ST_HOLD   = 3'd2,
        ST_FORCED = 3'd3,
        ST_BATT   = 3'd4
    } dsel_state_e;

endpackage

// File: rtl/dsel_type_classify.sv
module dsel_type_classify #(
    parameter int                      TYPE_W  = 3,
    parameter logic [(1<<TYPE_W)-1:0]  HP_MASK = 8'b0011_1000
) (
    input  logic [TYPE_W-1:0] type_i,
    output logic              high_pwr_o
);
    localparam int N_CODES = 1 << TYPE_W;

    logic [N_CODES-1:0] hit;

    // one comparator per class code, enabled by its mask bit
    for (genvar g = 0; g < N_CODES; g++) begin : g_code
        if (HP_MASK[g]) begin : g_on
            assign hit[g] = (type_i == TYPE_W'(g));
        end else begin : g_off
            assign hit[g] = 1'b0;
        end
    end

    assign high_pwr_o = |hit;
endmodule

// File: rtl/dsel_result_latch.sv
module dsel_result_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic present_i,
    input  logic done_i,
    input  logic high_pwr_i,
    output logic hp_next_o,
    output logic hp_q_o
);
    // input removal wins over a result arriving in the same cycle
    always_comb begin
        if (!present_i)
            hp_next_o = 1'b0;
        else if (done_i)
            hp_next_o = high_pwr_i;
        else
            hp_next_o = hp_q_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hp_q_o <= 1'b0;
        else
            hp_q_o <= hp_next_o;
    end
endmodule

// File: rtl/dsel_fsm.sv
module dsel_fsm
    import dsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic batt_block_i,
    input  logic force_ok_i,
    input  logic busy_ok_i,
    input  logic hp_i,
    output logic sel_o
);
    dsel_state_e state_q, state_d, target;
    logic        sel_q;

    // fixed priority: battery low, force, detection, latched result
    always_comb begin
        if (batt_block_i)
            target = ST_BATT;
        else if (force_ok_i)
            target = ST_FORCED;
        else if (busy_ok_i)
            target = ST_DETECT;
        else if (hp_i)
            target = ST_HOLD;
        else
            target = ST_LOW;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:    state_d = target;
            ST_DETECT: state_d = target;
            ST_HOLD:   state_d = target;
            ST_FORCED: state_d = target;
            ST_BATT:   state_d = target;
            default:   state_d = ST_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_LOW;
        else
            state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sel_q <= 1'b0;
        else
            sel_q <= (state_d == ST_DETECT) || (state_d == ST_HOLD) ||
                     (state_d == ST_FORCED);
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/dsel_mux_ctrl.sv
module dsel_mux_ctrl
    import dsel_pkg::*;
#(
    parameter int                      TYPE_W  = DEF_TYPE_W,
    parameter logic [(1<<TYPE_W)-1:0]  HP_MASK = DEF_HP_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_auto_en_i,
    input  logic              det_force_i,
    input  logic              det_busy_i,
    input  logic              det_done_i,
    input  logic [TYPE_W-1:0] det_type_i,
    input  logic              in_present_i,
    input  logic              otg_on_i,
    input  logic              batt_only_i,
    input  logic              force_sel_i,
    output logic              sel_o
);
    logic det_en;
    logic busy_ok;
    logic done_ok;
    logic force_ok;
    logic batt_block;
    logic code_hp;
    logic hp_next;
    logic hp_q;

    assign det_en     = det_auto_en_i | det_force_i;
    assign busy_ok    = det_busy_i & det_en;
    assign done_ok    = det_done_i & det_en;
    assign force_ok   = force_sel_i & (in_present_i | otg_on_i);
    assign batt_block = batt_only_i & ~otg_on_i;

    dsel_type_classify #(
        .TYPE_W  (TYPE_W),
        .HP_MASK (HP_MASK)
    ) u_classify (
        .type_i     (det_type_i),
        .high_pwr_o (code_hp)
    );

    dsel_result_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .present_i  (in_present_i),
        .done_i     (done_ok),
        .high_pwr_i (code_hp),
        .hp_next_o  (hp_next),
        .hp_q_o     (hp_q)
    );

    dsel_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .batt_block_i (batt_block),
        .force_ok_i   (force_ok),
        .busy_ok_i    (busy_ok),
        .hp_i         (hp_next),
        .sel_o        (sel_o)
    );

    logic unused_hp;
    assign unused_hp = hp_q;
endmodule

// File: rtl/dsel_mux_ctrl_chk.sv
module dsel_mux_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic det_auto_en_i,
    input logic det_force_i,
    input logic det_busy_i,
    input logic in_present_i,
    input logic otg_on_i,
    input logic batt_only_i,
    input logic force_sel_i,
    input logic sel_o
);
    p_batt_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_only_i && !otg_on_i) |=> !sel_o);

    p_force_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_sel_i && (in_present_i || otg_on_i) && !(batt_only_i && !otg_on_i))
        |=> sel_o);

    p_busy_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (det_busy_i && (det_auto_en_i || det_force_i) && !(batt_only_i && !otg_on_i))
        |=> sel_o);

    p_removed_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_present_i && !otg_on_i && !(det_busy_i && (det_auto_en_i || det_force_i)))
        |=> !sel_o);
endmodule

bind dsel_mux_ctrl dsel_mux_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .det_auto_en_i (det_auto_en_i),
    .det_force_i   (det_force_i),
    .det_busy_i    (det_busy_i),
    .in_present_i  (in_present_i),
    .otg_on_i      (otg_on_i),
    .batt_only_i   (batt_only_i),
    .force_sel_i   (force_sel_i),
    .sel_o         (sel_o)
);

// File: tb/dsel_mux_ctrl_tb.sv
`timescale 1ns/1ps
module dsel_mux_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       auto_en, fdet, busy, done, present, otg, batt, force_sel;
    logic [2:0] dtype;
    logic       sel;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    dsel_mux_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .det_auto_en_i (auto_en),
        .det_force_i   (fdet),
        .det_busy_i    (busy),
        .det_done_i    (done),
        .det_type_i    (dtype),
        .in_present_i  (present),
        .otg_on_i      (otg),
        .batt_only_i   (batt),
        .force_sel_i   (force_sel),
        .sel_o         (sel)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (sel !== exp) begin
            n_errors++;
            $display("FAIL %s: sel actual=%b expected=%b", req, sel, exp);
        end
    endtask

    task automatic idle_inputs();
        auto_en = 0; fdet = 0; busy = 0; done = 0; dtype = 3'd0;
        present = 0; otg = 0; batt = 0; force_sel = 0;
    endtask

    task automatic run_detect(input logic [2:0] code);
        busy = 1; step();
        busy = 0; done = 1; dtype = code; step();
        done = 0; step();
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 0;
        repeat (3) step();
        check("R1 during reset", 1'b0);
        rst_n = 1; step();
        check("R1 after reset", 1'b0);
    endtask

    task automatic t_detect_hp();
        for (int c = 3; c <= 5; c++) begin
            idle_inputs(); step();
            present = 1; auto_en = 1;
            busy = 1; step();
            check("R2 busy high", 1'b1);
            busy = 0; done = 1; dtype = 3'(c); step();
            check("R4 done hp", 1'b1);
            done = 0; step();
            check("R4 hold hp", 1'b1);
            present = 0; step();
            check("R6 removed", 1'b0);
            present = 1; step();
            check("R6 stays low after return", 1'b0);
        end
    endtask

    task automatic t_detect_other();
        int codes[5] = '{0, 1, 2, 6, 7};
        foreach (codes[i]) begin
            idle_inputs(); present = 1; auto_en = 1; step();
            run_detect(3'(codes[i]));
            check("R5 non-hp low", 1'b0);
        end
    endtask

    task automatic t_disabled();
        idle_inputs(); present = 1; step();
        busy = 1; step();
        check("R3 busy ignored", 1'b0);
        busy = 0; done = 1; dtype = 3'd3; step();
        check("R3 done ignored", 1'b0);
        done = 0; step();
        check("R3 nothing latched", 1'b0);
        fdet = 1; busy = 1; step();
        check("R2 forced detection busy", 1'b1);
        busy = 0; done = 1; dtype = 3'd4; step();
        done = 0; fdet = 0; step();
        check("R4 forced detection hold", 1'b1);
    endtask

    task automatic t_force();
        idle_inputs(); present = 1; auto_en = 1; step();
        run_detect(3'd1);
        force_sel = 1; step();
        check("R7 force with input", 1'b1);
        present = 0; otg = 1; step();
        check("R7 force with otg", 1'b1);
        otg = 0; step();
        check("R8 force no input no otg", 1'b0);
        force_sel = 0; step();
        check("R8 after release", 1'b0);
    endtask

    task automatic t_batt();
        idle_inputs(); present = 1; auto_en = 1; step();
        run_detect(3'd5);
        check("R4 setup", 1'b1);
        batt = 1; step();
        check("R9 batt over latched", 1'b0);
        force_sel = 1; busy = 1; step();
        check("R9 batt over force and busy", 1'b0);
        busy = 0; otg = 1; step();
        check("R10 otg keeps force", 1'b1);
        batt = 0; otg = 0; force_sel = 0; step();
        check("R9 latched result returns", 1'b1);
    endtask

    initial begin
        t_reset();
        t_detect_hp();
        t_detect_other();
        t_disabled();
        t_force();
        t_batt();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule